// File: doc/BRIEF.md
# Camera Link Bring-Up Sequencer

This block is the control engine that takes a serial camera receiver and its D-PHY from full reset to a running link. A single start pulse, together with the number of data lanes the sensor will use, launches a fixed walk. The walk enables the pixel clock and loads the lane-configuration output. It then lets the PHY out of shutdown, out of reset, and finally lets the receiver controller out of reset. After that it asks the sensor to hold its lanes in the low-power idle state and polls the PHY status word until every used lane and the clock lane report stop state.

Next it asks the sensor to stream and polls for a high-speed clock on the clock lane. Each poll gives up after a parameterised number of system-clock cycles, which stands in for half a second of wall time. A missed idle state only raises a warning pulse and the walk continues. A missed clock is fatal: the sequencer withdraws its requests and resets in the reverse of the order it raised them. A stop pulse from the running state takes the same reverse path. Completion is signalled by a one-cycle done pulse next to a sticky two-bit result code.

Top module: `camLinkBringup`

## Requirements
- R1: On an accepted start the lane-configuration output takes the requested lane count minus one. It then holds that value for as long as the controller reset stays released.
- R2: After reset all six enable outputs are low. An accepted start raises the pixel-clock enable one cycle after the start is sampled, then the PHY shutdown release, the PHY reset release and the controller reset release, one per cycle in that order.
- R3: A start whose lane count is 0 or above MAX_LANES is refused. One cycle later the done pulse fires with result code 2 (lane-count error), no enable output moves and the lane-configuration output keeps its old value.
- R4: The idle-state poll passes in the first cycle where status bit 10 (clock-lane stop state) and status bits 4 up to 4+N-1 (data-lane stop states, N = lane count) are all one. Stop-state bits of unused lanes and all other status bits are ignored.
- R5: If the idle-state poll has not passed after TIMEOUT_CYC cycles, a one-cycle warning pulse fires and the walk continues. A passing poll never raises the warning.
- R6: The low-power hold request rises one cycle after the controller reset release. The stream request rises one cycle after the idle-state poll ends, whether it passed or timed out.
- R7: The clock poll watches status bit 8 (high-speed clock active). When it is seen, done pulses the next cycle with result code 0, and all enables and requests stay high.
- R8: If bit 8 has not been seen within TIMEOUT_CYC cycles, the sequencer drops the stream request, then the low-power hold request, then all three resets together, then the pixel-clock enable, one per cycle. Done pulses with the clock drop and the result code becomes 1 (clock-lane timeout).
- R9: A stop pulse in the running state follows the same four-step unwind. Done pulses with the clock drop and the result code is left unchanged.
- R10: A start pulse while a walk is in progress or running is ignored. A stop pulse outside the running state is ignored.
- R11: The result code changes only in a cycle where the done pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to bring the link up |
| stopReq | input | 1 | One-cycle request to shut a running link down |
| laneCount | input | LANE_W | Number of data lanes to use |
| phyStatus | input | STAT_W | PHY status word (lane stop states, clock activity) |
| laneCfg | output | LANE_W | Lane-configuration value (lanes minus one) |
| phyShutdownN | output | 1 | High releases PHY shutdown |
| phyResetN | output | 1 | High releases PHY reset |
| ctrlResetN | output | 1 | High releases receiver controller reset |
| pixClkEn | output | 1 | Pixel-clock enable |
| sensorLpReq | output | 1 | Asks the sensor to hold its lanes in low-power idle |
| sensorStreamReq | output | 1 | Asks the sensor to stream |
| lp11Warn | output | 1 | One-cycle warning: idle-state poll timed out |
| doneP | output | 1 | One-cycle completion pulse |
| errCode | output | 2 | Sticky result: 0 none, 1 clock timeout, 2 lane-count error |

## Verification
The assertions assume that start and stop arrive as single-cycle pulses on a synchronous clock. They also assume that the lane count and status word are settled at the edge where they are sampled, and that MAX_LANES is at most four, so the data-lane stop-state field fits below the clock-active bit. The stimulus changes every input only at falling edges. It keeps the lane count fixed from the start pulse until done, and holds each status pattern constant across a whole walk. The stimulus sweeps every lane count, every data-lane stop-state pattern, both clock-lane stop values and both clock outcomes, with deliberately noisy unused bits.

// File: rtl/camLinkPkg.sv
package camLinkPkg;

  // status word field positions (decoded by the PHY side)
  localparam int STOP_DATA_LSB = 4;
  localparam int CLK_HS_BIT    = 8;
  localparam int CLK_STOP_BIT  = 10;

  localparam logic [1:0] RES_NONE   = 2'd0;
  localparam logic [1:0] RES_CLK_TO = 2'd1;
  localparam logic [1:0] RES_LANES  = 2'd2;

  typedef enum logic [3:0] {
    stIdle, stClkOn, stPhyOn, stPhyRst, stCtlRst, stLpReq, stWaitLp,
    stStreamReq, stWaitClk, stRun, stUnStream, stUnLp, stUnRst, stUnClk
  } seqState_t;

  typedef struct packed {
    logic       loadLanes;
    logic       clkOn;
    logic       clkOff;
    logic       shdnRel;
    logic       phyRel;
    logic       ctlRel;
    logic       rstAll;
    logic       lpOn;
    logic       lpOff;
    logic       streamOn;
    logic       streamOff;
    logic       timerRun;
    logic       warn;
    logic       done;
    logic       resLoad;
    logic [1:0] resVal;
  } seqCmd_t;

endpackage

// File: rtl/camLinkCtrl.sv
module camLinkCtrl
  import camLinkPkg::*;
#(
  parameter int MAX_LANES = 4,
  parameter int LANE_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              stopReq,
  input  logic [LANE_W-1:0] laneCount,
  input  logic              lp11Ok,
  input  logic              clkActive,
  input  logic              timeUp,
  output seqCmd_t           cmd
);

  seqState_t state, stateNext;
  logic failReg, failNext;
  logic laneBad;

  assign laneBad = (laneCount == '0) || (laneCount > LANE_W'(MAX_LANES));

  always_comb begin
    cmd       = '0;
    stateNext = state;
    failNext  = failReg;
    unique case (state)
      stIdle: begin
        if (startReq) begin
          if (laneBad) begin
            cmd.done    = 1'b1;
            cmd.resLoad = 1'b1;
            cmd.resVal  = RES_LANES;
          end else begin
            stateNext = stClkOn;
          end
        end
      end
      stClkOn: begin
        cmd.loadLanes = 1'b1;
        cmd.clkOn     = 1'b1;
        stateNext     = stPhyOn;
      end
      stPhyOn: begin
        cmd.shdnRel = 1'b1;
        stateNext   = stPhyRst;
      end
      stPhyRst: begin
        cmd.phyRel = 1'b1;
        stateNext  = stCtlRst;
      end
      stCtlRst: begin
        cmd.ctlRel = 1'b1;
        stateNext  = stLpReq;
      end
      stLpReq: begin
        cmd.lpOn  = 1'b1;
        stateNext = stWaitLp;
      end
      stWaitLp: begin
        cmd.timerRun = 1'b1;
        if (lp11Ok) begin
          stateNext = stStreamReq;
        end else if (timeUp) begin
          cmd.warn  = 1'b1;
          stateNext = stStreamReq;
        end
      end
      stStreamReq: begin
        cmd.streamOn = 1'b1;
        stateNext    = stWaitClk;
      end
      stWaitClk: begin
        cmd.timerRun = 1'b1;
        if (clkActive) begin
          cmd.done    = 1'b1;
          cmd.resLoad = 1'b1;
          cmd.resVal  = RES_NONE;
          stateNext   = stRun;
        end else if (timeUp) begin
          failNext  = 1'b1;
          stateNext = stUnStream;
        end
      end
      stRun: begin
        if (stopReq) begin
          failNext  = 1'b0;
          stateNext = stUnStream;
        end
      end
      stUnStream: begin
        cmd.streamOff = 1'b1;
        stateNext     = stUnLp;
      end
      stUnLp: begin
        cmd.lpOff = 1'b1;
        stateNext = stUnRst;
      end
      stUnRst: begin
        cmd.rstAll = 1'b1;
        stateNext  = stUnClk;
      end
      stUnClk: begin
        cmd.clkOff  = 1'b1;
        cmd.done    = 1'b1;
        cmd.resLoad = failReg;
        cmd.resVal  = RES_CLK_TO;
        stateNext   = stIdle;
      end
      default: stateNext = stIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= stIdle;
      failReg <= 1'b0;
    end else begin
      state   <= stateNext;
      failReg <= failNext;
    end
  end

  // a refused start leaves the sequencer idle
  p_reject_stays_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == stIdle && startReq && laneBad) |=> (state == stIdle));

  // start pulses outside idle do not restart the walk
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == stRun && !stopReq) |=> (state == stRun));

endmodule

// File: rtl/camLinkDatapath.sv
module camLinkDatapath
  import camLinkPkg::*;
#(
  parameter int MAX_LANES   = 4,
  parameter int LANE_W      = 3,
  parameter int STAT_W      = 16,
  parameter int TIMEOUT_CYC = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [LANE_W-1:0] laneCount,
  input  logic [STAT_W-1:0] phyStatus,
  output logic [LANE_W-1:0] laneCfg,
  output logic              phyShutdownN,
  output logic              phyResetN,
  output logic              ctrlResetN,
  output logic              pixClkEn,
  output logic              sensorLpReq,
  output logic              sensorStreamReq,
  output logic              lp11Warn,
  output logic              doneP,
  output logic [1:0]        errCode,
  output logic              lp11Ok,
  output logic              clkActive,
  output logic              timeUp
);

  localparam int TIMER_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TIMER_W-1:0] TIMER_LAST = TIMER_W'(TIMEOUT_CYC - 1);
  localparam logic [STAT_W-1:0] USED_BITS =
      (STAT_W'(1) << CLK_STOP_BIT) | (STAT_W'(1) << CLK_HS_BIT) |
      (((STAT_W'(1) << MAX_LANES) - STAT_W'(1)) << STOP_DATA_LSB);

  logic [TIMER_W-1:0]   timer;
  logic [MAX_LANES-1:0] laneUsed;
  logic [MAX_LANES-1:0] laneStopOk;
  logic                 unusedStatBits;

  assign unusedStatBits = ^(phyStatus & ~USED_BITS);

  // per-lane stop-state qualification: lane i counts when i <= lanes-1
  for (genvar i = 0; i < MAX_LANES; i++) begin : gLane
    localparam logic [LANE_W-1:0] LANE_IDX = LANE_W'(i);
    assign laneUsed[i]   = (laneCfg >= LANE_IDX);
    assign laneStopOk[i] = phyStatus[STOP_DATA_LSB + i] | ~laneUsed[i];
  end

  assign lp11Ok    = phyStatus[CLK_STOP_BIT] & (&laneStopOk);
  assign clkActive = phyStatus[CLK_HS_BIT];
  assign timeUp    = (timer == TIMER_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (cmd.timerRun) begin
      timer <= timer + TIMER_W'(1);
    end else begin
      timer <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneCfg         <= '0;
      phyShutdownN    <= 1'b0;
      phyResetN       <= 1'b0;
      ctrlResetN      <= 1'b0;
      pixClkEn        <= 1'b0;
      sensorLpReq     <= 1'b0;
      sensorStreamReq <= 1'b0;
      lp11Warn        <= 1'b0;
      doneP           <= 1'b0;
      errCode         <= RES_NONE;
    end else begin
      lp11Warn <= cmd.warn;
      doneP    <= cmd.done;
      if (cmd.resLoad)   errCode         <= cmd.resVal;
      if (cmd.loadLanes) laneCfg         <= laneCount - LANE_W'(1);
      if (cmd.clkOn)     pixClkEn        <= 1'b1;
      if (cmd.clkOff)    pixClkEn        <= 1'b0;
      if (cmd.shdnRel)   phyShutdownN    <= 1'b1;
      if (cmd.phyRel)    phyResetN       <= 1'b1;
      if (cmd.ctlRel)    ctrlResetN      <= 1'b1;
      if (cmd.lpOn)      sensorLpReq     <= 1'b1;
      if (cmd.lpOff)     sensorLpReq     <= 1'b0;
      if (cmd.streamOn)  sensorStreamReq <= 1'b1;
      if (cmd.streamOff) sensorStreamReq <= 1'b0;
      if (cmd.rstAll) begin
        phyShutdownN <= 1'b0;
        phyResetN    <= 1'b0;
        ctrlResetN   <= 1'b0;
      end
    end
  end

  p_lanecfg_held_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlResetN && $past(ctrlResetN)) |-> $stable(laneCfg));

  p_shdn_after_clk_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyShutdownN) |-> pixClkEn);

  p_phy_after_shdn_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyResetN) |-> phyShutdownN);

  p_ctl_after_phy_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlResetN) |-> phyResetN);

  p_warn_only_on_miss_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.warn |-> !lp11Ok);

  p_stream_after_lp_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sensorStreamReq) |-> (sensorLpReq && ctrlResetN && phyResetN && phyShutdownN));

  p_clk_drop_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pixClkEn) |-> (!ctrlResetN && !phyResetN && !phyShutdownN &&
                         !sensorLpReq && !sensorStreamReq && doneP));

  p_result_with_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(errCode) |-> doneP);

endmodule

// File: rtl/camLinkBringup.sv
module camLinkBringup
  import camLinkPkg::*;
#(
  parameter int MAX_LANES   = 4,
  parameter int STAT_W      = 16,
  parameter int TIMEOUT_CYC = 50_000_000,
  localparam int LANE_W     = $clog2(MAX_LANES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              stopReq,
  input  logic [LANE_W-1:0] laneCount,
  input  logic [STAT_W-1:0] phyStatus,
  output logic [LANE_W-1:0] laneCfg,
  output logic              phyShutdownN,
  output logic              phyResetN,
  output logic              ctrlResetN,
  output logic              pixClkEn,
  output logic              sensorLpReq,
  output logic              sensorStreamReq,
  output logic              lp11Warn,
  output logic              doneP,
  output logic [1:0]        errCode
);

  seqCmd_t cmd;
  logic    lp11Ok;
  logic    clkActive;
  logic    timeUp;

  camLinkCtrl #(
    .MAX_LANES(MAX_LANES),
    .LANE_W   (LANE_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .stopReq  (stopReq),
    .laneCount(laneCount),
    .lp11Ok   (lp11Ok),
    .clkActive(clkActive),
    .timeUp   (timeUp),
    .cmd      (cmd)
  );

  camLinkDatapath #(
    .MAX_LANES  (MAX_LANES),
    .LANE_W     (LANE_W),
    .STAT_W     (STAT_W),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) uPath (
    .clk            (clk),
    .rstN           (rstN),
    .cmd            (cmd),
    .laneCount      (laneCount),
    .phyStatus      (phyStatus),
    .laneCfg        (laneCfg),
    .phyShutdownN   (phyShutdownN),
    .phyResetN      (phyResetN),
    .ctrlResetN     (ctrlResetN),
    .pixClkEn       (pixClkEn),
    .sensorLpReq    (sensorLpReq),
    .sensorStreamReq(sensorStreamReq),
    .lp11Warn       (lp11Warn),
    .doneP          (doneP),
    .errCode        (errCode),
    .lp11Ok         (lp11Ok),
    .clkActive      (clkActive),
    .timeUp         (timeUp)
  );

endmodule

// File: tb/camLinkBringup_test.sv
module camLinkBringup_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAXL       = 4;
  localparam int TO         = 8;
  localparam int LW         = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          stopReq = 1'b0;
  logic [LW-1:0] laneCount = '0;
  logic [15:0]   phyStatus = '0;
  logic [LW-1:0] laneCfg;
  logic          phyShutdownN, phyResetN, ctrlResetN, pixClkEn;
  logic          sensorLpReq, sensorStreamReq, lp11Warn, doneP;
  logic [1:0]    errCode;

  int checks = 0;
  int fails  = 0;
  int prevErr = 0;

  camLinkBringup #(.MAX_LANES(MAXL), .STAT_W(16), .TIMEOUT_CYC(TO)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .laneCount(laneCount), .phyStatus(phyStatus), .laneCfg(laneCfg),
    .phyShutdownN(phyShutdownN), .phyResetN(phyResetN), .ctrlResetN(ctrlResetN),
    .pixClkEn(pixClkEn), .sensorLpReq(sensorLpReq), .sensorStreamReq(sensorStreamReq),
    .lp11Warn(lp11Warn), .doneP(doneP), .errCode(errCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called after each falling edge: result code may only move with done (R11)
  task automatic watchErr();
    if (int'(errCode) != prevErr) begin
      check("R11 result moved without done", int'(doneP), 1);
      prevErr = int'(errCode);
    end
  endtask

  function automatic int enables();
    return {28'd0, pixClkEn, phyShutdownN, phyResetN, ctrlResetN};
  endfunction

  task automatic stopRun();
    int tStr = -1, tLp = -1, tRst = -1, tDone = -1, clkAt = -1, errAt = -1;
    @(negedge clk); stopReq = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); stopReq = 1'b0; watchErr();
      if (!sensorStreamReq && tStr < 0) tStr = k;
      if (!sensorLpReq && tLp < 0) tLp = k;
      if (!ctrlResetN && tRst < 0) tRst = k;
      if (doneP) begin tDone = k; clkAt = int'(pixClkEn); errAt = int'(errCode); break; end
    end
    check("R9 stream drop", tStr, 1);
    check("R9 hold drop", tLp, 2);
    check("R9 resets", tRst, 3);
    check("R9 done", tDone, 4);
    check("R9 clock off", clkAt, 0);
    check("R9 result kept", errAt, 0);
  endtask

  task automatic runSeq(int n, int d, int s, int c);
    int tClk = -1, tShdn = -1, tPrst = -1, tCrst = -1, tLp = -1, tStr = -1;
    int tWarn = -1, tDone = -1, tStrOff = -1, tLpOff = -1, tRstOff = -1;
    int errAt = -1, cfgAt = -1, enAt = -1, reqAt = -1;
    int lanesMask, lpOk, lenLp;
    lanesMask = (1 << n) - 1;
    lpOk  = (s == 1 && (d & lanesMask) == lanesMask) ? 1 : 0;
    lenLp = lpOk ? 1 : TO;
    @(negedge clk);
    laneCount = LW'(n);
    phyStatus = {5'd0, s[0], ~d[1], c[0], d[3:0], d[3:0]};
    startReq  = 1'b1;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk); startReq = 1'b0; watchErr();
      if (pixClkEn && tClk < 0) tClk = k;
      if (phyShutdownN && tShdn < 0) tShdn = k;
      if (phyResetN && tPrst < 0) tPrst = k;
      if (ctrlResetN && tCrst < 0) tCrst = k;
      if (sensorLpReq && tLp < 0) tLp = k;
      if (sensorStreamReq && tStr < 0) tStr = k;
      if (lp11Warn && tWarn < 0) tWarn = k;
      if (ctrlResetN) cfgAt = int'(laneCfg);
      if (tStr >= 0 && !sensorStreamReq && tStrOff < 0) tStrOff = k;
      if (tLp >= 0 && !sensorLpReq && tLpOff < 0) tLpOff = k;
      if (tCrst >= 0 && !ctrlResetN && tRstOff < 0) tRstOff = k;
      if (doneP) begin
        tDone = k; errAt = int'(errCode); enAt = enables();
        reqAt = {30'd0, sensorLpReq, sensorStreamReq};
        break;
      end
    end
    check("R2 clock enable", tClk, 1);
    check("R2 shutdown release", tShdn, 2);
    check("R2 phy reset release", tPrst, 3);
    check("R2 controller reset release", tCrst, 4);
    check("R1 lane config", cfgAt, n - 1);
    check("R6 hold request", tLp, 5);
    if (lpOk) check("R4 idle-state pass, no warning", tWarn, -1);
    else      check("R5 idle-state timeout warning", tWarn, 5 + lenLp);
    check("R4 stream request cycle", tStr, 6 + lenLp);
    if (c) begin
      check("R7 done cycle", tDone, 7 + lenLp);
      check("R7 result", errAt, 0);
      check("R7 enables held", enAt, 15);
      check("R7 requests held", reqAt, 3);
      // R10: start while running must be ignored
      @(negedge clk); laneCount = 3'd5; startReq = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); startReq = 1'b0; watchErr();
        if (doneP) tWarn = 99;
      end
      check("R10 start ignored, no done", (tWarn == 99) ? 1 : 0, 0);
      check("R10 start ignored, stream held", int'(sensorStreamReq), 1);
      stopRun();
    end else begin
      check("R8 stream drop", tStrOff, 7 + lenLp + TO);
      check("R8 hold drop", tLpOff, 8 + lenLp + TO);
      check("R8 resets", tRstOff, 9 + lenLp + TO);
      check("R8 done", tDone, 10 + lenLp + TO);
      check("R8 all off at done", enAt, 0);
      check("R8 result", errAt, 1);
    end
  endtask

  task automatic rejectRun(int n);
    int oldCfg;
    oldCfg = int'(laneCfg);
    @(negedge clk); laneCount = LW'(n); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0; watchErr();
    check("R3 done pulse", int'(doneP), 1);
    check("R3 result code", int'(errCode), 2);
    check("R3 enables untouched", enables(), 0);
    check("R3 lane config kept", int'(laneCfg), oldCfg);
    @(negedge clk); watchErr();
    check("R3 single pulse", int'(doneP), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset enables low", enables(), 0);
    check("R2 reset requests low", {30'd0, sensorLpReq, sensorStreamReq}, 0);
    check("R11 reset result", int'(errCode), 0);
    check("R2 reset done low", int'(doneP), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R10: stop outside running is ignored
    stopReq = 1'b1;
    @(negedge clk); stopReq = 1'b0;
    repeat (3) begin
      @(negedge clk); watchErr();
      check("R10 stop ignored in idle", int'(doneP) + enables(), 0);
    end
    rejectRun(0);
    for (int n = 1; n <= MAXL; n++)
      for (int d = 0; d < 16; d++)
        for (int s = 0; s < 2; s++)
          for (int c = 0; c < 2; c++)
            runSeq(n, d, s, c);
    rejectRun(5);
    rejectRun(7);
    runSeq(2, 3, 1, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule